// File: doc/BRIEF.md
# Reserved-load / conditional-store reservation unit

This block keeps a single memory reservation for a pair of atomic-update instructions: a load that marks a location, and a later store that writes only if the mark is still intact. It stands in front of a simple single-beat memory bus. Requests arrive one at a time with a valid strobe, a load/store flag, a reserve flag, an rc flag, an address, write data and byte selects.

A reserved load records the cache line of its address. A conditional store compares its own line against the record and then always drops the record. If the record was missing or names another line, the store is cancelled. No bus cycle is started, and a completion still appears one cycle later, reporting that nothing was stored. A store that is allowed goes out as a bus write and completes after the acknowledge.

Completions that carry rc produce a 4-bit condition value and a write enable aimed at condition field 0. The stored flag and a summary-overflow input are folded into that value.

Top module: `llsc_guard`

## Requirements
- R1: While reset is high and in the first cycle after it, stall, busCyc, busStb, busWe and doneValid are 0, and no reservation is held.
- R2: An accepted request with reqReserve=1 and reqLoad=1 makes the reservation valid and records the address bits above the low LINE_BITS bits. A later reserved load replaces the recorded line.
- R3: An accepted conditional store (reqReserve=1, reqLoad=0) succeeds when the reservation is valid and its line matches. The address bits below LINE_BITS do not take part in the match. A successful one starts a bus write.
- R4: A conditional store with no valid reservation, or with a line that does not match, is cancelled. busCyc, busStb and busWe stay 0, and stall stays 0.
- R5: Every accepted conditional store leaves the reservation invalid, whether it succeeded or was cancelled.
- R6: In the cycle after a cancelled store is accepted, doneValid=1, doneStored=0 and doneRc equals the request's reqRc.
- R7: In the cycle after a bus acknowledge, doneValid=1. A store then reports doneStored=1 and doneRc equal to its reqRc. A load reports doneStored=0 and doneRc=0.
- R8: crWrEn equals doneValid AND doneRc. crMask has only its top bit set, which selects field 0. crNibble is {0, 0, doneStored, soIn}, with bit 3 first.
- R9: A bus cycle raises busCyc and busStb until the cycle after busAck. busWe is 1 for stores and 0 for loads. busAdr is reqAddr with its low 3 bits cleared, and busDat and busSel copy the request.
- R10: stall is 1 exactly while a bus cycle is outstanding. Requests presented while stall is 1 are ignored, including any effect on the reservation.
- R11: A store with reqReserve=0 never checks or changes the reservation and always starts a bus write.
- R12: A cancelled-store completion and an acknowledge completion never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqLoad | input | 1 | 1 for load, 0 for store |
| reqReserve | input | 1 | Reserved load or conditional store |
| reqRc | input | 1 | Request wants a condition result |
| reqAddr | input | ADDR_W | Byte address |
| reqData | input | DATA_W | Store data |
| reqSel | input | DATA_W/8 | Byte selects |
| soIn | input | 1 | Summary-overflow bit folded into the condition value |
| stall | output | 1 | Controller busy, request not accepted |
| busCyc | output | 1 | Bus cycle active |
| busStb | output | 1 | Bus strobe |
| busWe | output | 1 | Bus write enable |
| busAdr | output | ADDR_W | Word-aligned bus address |
| busDat | output | DATA_W | Bus write data |
| busSel | output | DATA_W/8 | Bus byte selects |
| busAck | input | 1 | Bus acknowledge |
| doneValid | output | 1 | Completion pulse |
| doneRc | output | 1 | Completion carries a condition result |
| doneStored | output | 1 | Store reached memory |
| crWrEn | output | 1 | Condition field write enable |
| crMask | output | CR_FIELDS | Condition field select, top bit is field 0 |
| crNibble | output | 4 | Condition value |

## Verification
The bench builds the block with LINE_BITS=4, so that lines are 16 bytes long. With this setting a small set of addresses spans several neighbouring lines as well as several offsets inside one line. Matching and mismatching conditional stores therefore both happen often, both in the directed cases and in the random phase. Acknowledge latency cycles from zero to three wait states. This covers acknowledges that arrive one cycle after a write starts, and requests that hit a stalled controller.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctrlState_e;

  // Strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic captureReq;  // request accepted: latch its completion attributes
    logic startBus;    // launch a bus cycle
    logic endBus;      // acknowledge seen: drop the bus cycle
    logic setRsv;      // reserved load: record line
    logic clrRsv;      // conditional store: drop reservation
    logic failNow;     // conditional store cancelled
  } ctrlStrobe_t;

endpackage

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqLoad,
  input  logic        reqReserve,
  input  logic        rsvHit,
  input  logic        busAck,
  output ctrlStrobe_t strobe,
  output logic        stall,
  output logic        cancel
);

  ctrlState_e state;
  logic accept;
  logic isCond;

  assign accept = reqValid && (state == ST_IDLE);
  assign isCond = accept && reqReserve && !reqLoad;
  assign cancel = isCond && !rsvHit;

  always_comb begin
    strobe            = '0;
    strobe.captureReq = accept;
    strobe.startBus   = accept && !cancel;
    strobe.endBus     = (state == ST_WAIT) && busAck;
    strobe.setRsv     = accept && reqReserve && reqLoad;
    strobe.clrRsv     = isCond;
    strobe.failNow    = cancel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (strobe.startBus) state <= ST_WAIT;
        ST_WAIT: if (busAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign stall = (state != ST_IDLE);

endmodule

// File: rtl/llsc_datapath.sv
module llsc_datapath
  import llsc_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int LINE_BITS = 6,
  parameter int CR_FIELDS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ctrlStrobe_t            strobe,
  input  logic                   reqLoad,
  input  logic                   reqRc,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqData,
  input  logic [DATA_W/8-1:0]    reqSel,
  input  logic                   soIn,
  output logic                   rsvHit,
  output logic                   busCyc,
  output logic                   busStb,
  output logic                   busWe,
  output logic [ADDR_W-1:0]      busAdr,
  output logic [DATA_W-1:0]      busDat,
  output logic [DATA_W/8-1:0]    busSel,
  output logic                   failPulse,
  output logic                   ackPulse,
  output logic                   doneValid,
  output logic                   doneRc,
  output logic                   doneStored,
  output logic                   crWrEn,
  output logic [CR_FIELDS-1:0]   crMask,
  output logic [3:0]             crNibble
);

  localparam int SEL_W     = DATA_W / 8;
  localparam int WORD_BITS = $clog2(SEL_W);
  localparam int TAG_W     = ADDR_W - LINE_BITS;
  localparam logic [ADDR_W-1:0]    ALIGN_MASK = ~((ADDR_W'(1) << WORD_BITS) - ADDR_W'(1));
  localparam logic [CR_FIELDS-1:0] FIELD0     = CR_FIELDS'(1) << (CR_FIELDS - 1);

  logic             rsvValid;
  logic [TAG_W-1:0] rsvTag;
  logic             pendRc;
  logic             pendStore;

  // Reservation record
  assign rsvHit = rsvValid && (reqAddr[ADDR_W-1:LINE_BITS] == rsvTag);

  always_ff @(posedge clk) begin
    if (rst || strobe.clrRsv) begin
      rsvValid <= 1'b0;
    end else if (strobe.setRsv) begin
      rsvValid <= 1'b1;
      rsvTag   <= reqAddr[ADDR_W-1:LINE_BITS];
    end
  end

  // Bus master registers
  always_ff @(posedge clk) begin
    if (rst) begin
      busCyc <= 1'b0;
      busStb <= 1'b0;
      busWe  <= 1'b0;
    end else if (strobe.startBus) begin
      busCyc <= 1'b1;
      busStb <= 1'b1;
      busWe  <= !reqLoad;
      busAdr <= reqAddr & ALIGN_MASK;
      busDat <= reqData;
      busSel <= reqSel;
    end else if (strobe.endBus) begin
      busCyc <= 1'b0;
      busStb <= 1'b0;
      busWe  <= 1'b0;
    end
  end

  // Completion attributes and one-cycle pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      failPulse <= 1'b0;
      ackPulse  <= 1'b0;
      pendRc    <= 1'b0;
      pendStore <= 1'b0;
    end else begin
      failPulse <= strobe.failNow;
      ackPulse  <= strobe.endBus;
      if (strobe.captureReq) begin
        pendRc    <= reqRc;
        pendStore <= !reqLoad;
      end
    end
  end

  assign doneValid  = failPulse || ackPulse;
  assign doneStored = ackPulse && pendStore;
  assign doneRc     = pendRc && (failPulse || (ackPulse && pendStore));
  assign crWrEn     = doneValid && doneRc;
  assign crMask     = FIELD0;
  assign crNibble   = {2'b00, doneStored, soIn};

endmodule

// File: rtl/llsc_guard.sv
module llsc_guard
  import llsc_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int LINE_BITS = 6,
  parameter int CR_FIELDS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  input  logic                 reqLoad,
  input  logic                 reqReserve,
  input  logic                 reqRc,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqData,
  input  logic [DATA_W/8-1:0]  reqSel,
  input  logic                 soIn,
  output logic                 stall,
  output logic                 busCyc,
  output logic                 busStb,
  output logic                 busWe,
  output logic [ADDR_W-1:0]    busAdr,
  output logic [DATA_W-1:0]    busDat,
  output logic [DATA_W/8-1:0]  busSel,
  input  logic                 busAck,
  output logic                 doneValid,
  output logic                 doneRc,
  output logic                 doneStored,
  output logic                 crWrEn,
  output logic [CR_FIELDS-1:0] crMask,
  output logic [3:0]           crNibble
);

  ctrlStrobe_t strobe;
  logic rsvHit;
  logic cancel;
  logic failPulse;
  logic ackPulse;

  llsc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .reqLoad   (reqLoad),
    .reqReserve(reqReserve),
    .rsvHit    (rsvHit),
    .busAck    (busAck),
    .strobe    (strobe),
    .stall     (stall),
    .cancel    (cancel)
  );

  llsc_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LINE_BITS(LINE_BITS),
    .CR_FIELDS(CR_FIELDS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .reqLoad   (reqLoad),
    .reqRc     (reqRc),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .reqSel    (reqSel),
    .soIn      (soIn),
    .rsvHit    (rsvHit),
    .busCyc    (busCyc),
    .busStb    (busStb),
    .busWe     (busWe),
    .busAdr    (busAdr),
    .busDat    (busDat),
    .busSel    (busSel),
    .failPulse (failPulse),
    .ackPulse  (ackPulse),
    .doneValid (doneValid),
    .doneRc    (doneRc),
    .doneStored(doneStored),
    .crWrEn    (crWrEn),
    .crMask    (crMask),
    .crNibble  (crNibble)
  );

endmodule

// File: rtl/llsc_guard_chk.sv
module llsc_guard_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqLoad,
  input logic              reqReserve,
  input logic              cancel,
  input logic              stall,
  input logic              busCyc,
  input logic              busStb,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAdr,
  input logic              busAck,
  input logic              failPulse,
  input logic              ackPulse,
  input logic              doneValid,
  input logic              doneRc,
  input logic              doneStored,
  input logic              crWrEn,
  input logic [3:0]        crNibble,
  input logic              soIn
);

  assert_stall_bus_R10: assert property (@(posedge clk) disable iff (rst)
    stall |-> (busCyc && busStb));

  assert_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    busCyc |-> (busAdr[2:0] == 3'b000));

  assert_plain_store_R11: assert property (@(posedge clk) disable iff (rst)
    (!stall && reqValid && !reqReserve && !reqLoad) |=> (busCyc && busWe));

  assert_cancel_no_bus_R4: assert property (@(posedge clk) disable iff (rst)
    cancel |=> (!busCyc && !stall && failPulse));

  assert_fail_done_R6: assert property (@(posedge clk) disable iff (rst)
    failPulse |-> (doneValid && !doneStored));

  assert_ack_done_R7: assert property (@(posedge clk) disable iff (rst)
    (busCyc && busAck) |=> (doneValid && ackPulse && !stall));

  assert_nibble_R8: assert property (@(posedge clk) disable iff (rst)
    crWrEn |-> (doneValid && doneRc && crNibble[3:2] == 2'b00
                && crNibble[1] == doneStored && crNibble[0] == soIn));

  assert_no_coincide_R12: assert property (@(posedge clk) disable iff (rst)
    !(failPulse && ackPulse));

endmodule

bind llsc_guard llsc_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reqValid  (reqValid),
  .reqLoad   (reqLoad),
  .reqReserve(reqReserve),
  .cancel    (cancel),
  .stall     (stall),
  .busCyc    (busCyc),
  .busStb    (busStb),
  .busWe     (busWe),
  .busAdr    (busAdr),
  .busAck    (busAck),
  .failPulse (failPulse),
  .ackPulse  (ackPulse),
  .doneValid (doneValid),
  .doneRc    (doneRc),
  .doneStored(doneStored),
  .crWrEn    (crWrEn),
  .crNibble  (crNibble),
  .soIn      (soIn)
);

// File: tb/llsc_guard_bench.sv
`timescale 1ns/1ps
module llsc_guard_bench;
  localparam int LB = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic reqValid = 0, reqLoad = 0, reqReserve = 0, reqRc = 0, soIn = 0;
  logic [63:0] reqAddr = '0, reqData = '0;
  logic [7:0]  reqSel = '0;
  logic busAck = 0;
  logic stall, busCyc, busStb, busWe, doneValid, doneRc, doneStored, crWrEn;
  logic [63:0] busAdr, busDat;
  logic [7:0] busSel, crMask;
  logic [3:0] crNibble;

  llsc_guard #(.LINE_BITS(LB)) u_llsc_guard (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqLoad(reqLoad),
    .reqReserve(reqReserve), .reqRc(reqRc), .reqAddr(reqAddr),
    .reqData(reqData), .reqSel(reqSel), .soIn(soIn), .stall(stall),
    .busCyc(busCyc), .busStb(busStb), .busWe(busWe), .busAdr(busAdr),
    .busDat(busDat), .busSel(busSel), .busAck(busAck),
    .doneValid(doneValid), .doneRc(doneRc), .doneStored(doneStored),
    .crWrEn(crWrEn), .crMask(crMask), .crNibble(crNibble)
  );

  integer checks = 0, errors = 0, doneCount = 0;
  logic lastStored = 0, lastRc = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated on each rising edge
  bit mBusy = 0, mWe = 0, mRsvV = 0, eValid = 0, eRc = 0, eStored = 0;
  bit pendStore = 0, pendRc = 0, mFail = 0;
  logic [63:0] mAdr, mDat, mRsvLine;
  logic [7:0] mSel;

  always @(posedge clk) begin
    if (rst) begin
      mBusy = 0; mRsvV = 0; eValid = 0; eRc = 0; eStored = 0;
    end else begin
      eValid = 0; eRc = 0; eStored = 0;
      if (mBusy) begin
        if (busAck) begin
          mBusy = 0; eValid = 1; eStored = pendStore; eRc = pendStore && pendRc;
        end
      end else if (reqValid) begin
        mFail = 0;
        if (reqReserve && reqLoad) begin
          mRsvV = 1; mRsvLine = reqAddr >> LB;
        end else if (reqReserve) begin
          mFail = !(mRsvV && ((reqAddr >> LB) == mRsvLine));
          mRsvV = 0;
        end
        if (mFail) begin
          eValid = 1; eRc = reqRc;
        end else begin
          mBusy = 1; mWe = !reqLoad; mAdr = {reqAddr[63:3], 3'b000};
          mDat = reqData; mSel = reqSel; pendStore = !reqLoad; pendRc = reqRc;
        end
      end
    end
  end

  // Compare on every clock, away from the edge
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      check("R10 stall", stall, mBusy);
      check("R9 busCyc", busCyc, mBusy);
      check("R9 busStb", busStb, mBusy);
      if (mBusy) begin
        check("R9 busWe", busWe, mWe);
        check("R9 busAdr", busAdr, mAdr);
        check("R9 busDat", busDat, mDat);
        check("R9 busSel", busSel, mSel);
      end else begin
        check("R4 busWe idle", busWe, 0);
      end
      check("R6 R7 doneValid", doneValid, eValid);
      check("R6 R7 doneStored", doneStored, eStored);
      check("R6 R7 doneRc", doneRc, eRc);
      check("R8 crWrEn", crWrEn, eValid && eRc);
      check("R8 crMask", crMask, 8'h80);
      if (crWrEn) check("R8 crNibble", crNibble, {2'b00, eStored, soIn});
      if (doneValid) begin
        doneCount++; lastStored = doneStored; lastRc = doneRc;
      end
    end
  end

  // Bus responder with rotating latency
  integer lat = 0, waitCnt = 0;
  always @(negedge clk) begin
    if (rst) begin
      busAck <= 0; waitCnt <= 0;
    end else if (busCyc && !busAck) begin
      if (waitCnt >= lat) busAck <= 1;
      else waitCnt <= waitCnt + 1;
    end else begin
      busAck <= 0; waitCnt <= 0;
    end
  end

  task automatic issue(input bit ld, input bit rsv, input bit rc, input logic [63:0] a,
                       input bit intrude, input logic [63:0] b);
    integer start;
    start = doneCount;
    @(negedge clk);
    reqValid = 1; reqLoad = ld; reqReserve = rsv; reqRc = rc; reqAddr = a;
    reqData = {~a[31:0], a[31:0]}; reqSel = a[7:0] | 8'h01; soIn = a[5] ^ a[2];
    @(negedge clk);
    reqValid = 0;
    if (intrude && stall) begin
      reqValid = 1; reqLoad = 1; reqReserve = 1; reqAddr = b;
      @(negedge clk);
      reqValid = 0;
    end
    while (doneCount == start) @(negedge clk);
    lat = (lat + 1) % 4;
  endtask

  task automatic stcx(input logic [63:0] a, input bit expStored, input string tag);
    issue(0, 1, 1, a, 0, 0);
    check(tag, lastStored, expStored);
    check({tag, " rc"}, lastRc, 1);
  endtask

  localparam logic [63:0] A  = 64'h0000_0000_0000_1040;
  localparam logic [63:0] B  = 64'h0000_0000_0000_1050;  // next 16-byte line
  localparam logic [63:0] C  = 64'h0000_0000_0000_2000;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 stall in reset", stall, 0);
    check("R1 busCyc in reset", busCyc, 0);
    check("R1 doneValid in reset", doneValid, 0);
    rst = 0;
    @(negedge clk);
    check("R1 busCyc after reset", busCyc, 0);
    check("R1 doneValid after reset", doneValid, 0);

    // R1: no reservation after reset
    stcx(A, 0, "R1 R4 stcx without reservation");
    // R11: plain store writes
    issue(0, 0, 0, C, 0, 0);
    check("R11 plain store stored", lastStored, 1);
    // R2 R3: same line, different offset
    issue(1, 1, 0, A, 0, 0);
    check("R7 load doneRc", lastRc, 0);
    check("R7 load doneStored", lastStored, 0);
    stcx(A + 64'h7, 1, "R3 stcx same line");
    // R5: cleared after success
    stcx(A, 0, "R5 stcx after success");
    // R11: plain store leaves reservation
    issue(1, 1, 0, A, 0, 0);
    issue(0, 0, 1, B, 0, 0);
    check("R7 plain store rc", lastRc, 1);
    stcx(A, 1, "R11 reservation kept across plain store");
    // R4 R5: mismatch fails and clears
    issue(1, 1, 0, A, 0, 0);
    stcx(B, 0, "R4 stcx other line");
    stcx(A, 0, "R5 stcx after failed one");
    // R2: later reserved load replaces the line
    issue(1, 1, 0, A, 0, 0);
    issue(1, 1, 0, B, 0, 0);
    stcx(A, 0, "R2 replaced line");
    issue(1, 1, 0, A, 0, 0);
    stcx(A, 1, "R2 fresh line");
    // R6: rc=0 cancelled store
    issue(0, 1, 0, A, 0, 0);
    check("R6 cancelled rc0", lastRc, 0);
    check("R6 cancelled stored", lastStored, 0);
    // R10: reserved load during stall ignored
    issue(0, 0, 0, C, 1, A);
    stcx(A, 0, "R10 stalled request ignored");

    // Random phase, compared every cycle by the model
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      int op;
      a = 64'h1000 + ({60'd0, 4'($urandom % 3)} << LB) + 64'($urandom % 16);
      op = $urandom % 4;
      issue(op == 0 || op == 1, op != 2, $urandom % 2, a, $urandom % 2,
            64'h1000 + 64'($urandom % 48));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule